// File: doc/BRIEF.md
# Configuration Word Merge Hub

The hub collects configuration writes from several independent sources and puts them, one after another, on a single shared broadcast bus. Source index 0 is the word stream recovered from the serial configuration link. Source indices 1 through N are the dedicated panel return channels, where N is set when the block is instantiated. Every write on every channel is a pair of 16-bit words: an address word followed by a value word. In the address word the upper byte names the panel and the lower byte names the device on that panel. The hub passes both words on unchanged.

All input channels and the bus output use a valid/ready handshake. A source is picked only while the hub waits for an address word. The selection is round-robin across the serial source and the panel channels. After an address word is taken, the hub takes its value word only from the same source, so a pair always appears on the bus as two adjacent words. The bus output is one registered word. When the bus keeps ready high, that register is refilled every cycle.

Top module: `cfgbus_hub`

## Requirements
- R1: A synchronous active-high reset empties the output (`bus_valid` low) and returns the hub to waiting for an address word. With no input valid after reset, every input ready is low.
- R2: Every pair taken from a source appears on the bus as two adjacent words, address then value. Both words carry the same `bus_src`. `bus_addr_phase` is 1 on the address word and 0 on the value word.
- R3: Between taking an address word from source s and taking its value word, no other source sees its ready asserted, even if it is presenting valid data and s is idle.
- R4: Source selection is round-robin. After reset the search starts at the serial source (index 0). After an address is taken from source g, the search starts at g+1, wrapping from N to 0. The first valid source in that order wins.
- R5: While `bus_valid` is high and `bus_ready` is low, `bus_data`, `bus_src` and `bus_addr_phase` hold their values and `bus_valid` stays high.
- R6: At most one input ready is high at any time. All input readies are low while the output word is stalled (`bus_valid` high, `bus_ready` low).
- R7: With `bus_ready` held high and the sources always presenting words, one word is taken each cycle. A batch of W words has fully left the bus W cycles after the first one was taken.
- R8: Data words pass through bit-for-bit, including the panel byte (bits 15:8) and the device byte (bits 7:0) of the address word.
- R9: The number of panel channels follows parameter N. Panel channel i (0-based) is source index i+1 and uses bits 16*i+15 to 16*i of `pnl_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_valid | input | 1 | Serial-link word valid |
| ser_ready | output | 1 | Serial-link word accepted |
| ser_data | input | 16 | Serial-link word |
| pnl_valid | input | N | Per-panel word valid |
| pnl_ready | output | N | Per-panel word accepted |
| pnl_data | input | 16*N | Panel words, channel i in bits 16*i+15 to 16*i |
| bus_valid | output | 1 | Shared bus word valid |
| bus_ready | input | 1 | Shared bus accepts the word |
| bus_data | output | 16 | Shared bus word |
| bus_addr_phase | output | 1 | 1 for an address word, 0 for a value word |
| bus_src | output | clog2(N+1) | Index of the source that supplied the word |

## Verification
The hardest case to reach is the ownership lock under pressure. An address word has been taken, the owner stops presenting while other sources keep valid high, and at the same time the bus stalls the output word. The stimulus table loads several pairs per source at once and applies irregular `bus_ready` patterns, so locks and stalls overlap in many combinations. A directed sequence then has the serial source go quiet between its address and value while a panel waits, and resets the hub with a pair half sent.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

    localparam int WORD_W  = 16;
    localparam int FIELD_W = 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        PH_ADDR  = 1'b0,
        PH_VALUE = 1'b1
    } phase_e;

    typedef struct packed {
        word_t data;
        logic  is_addr;
    } bus_word_t;

    // index width for a source count, never below one bit
    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/cfgbus_rr_pick.sv
module cfgbus_rr_pick #(
    parameter int S  = 4,
    parameter int IW = 2
) (
    input  logic [S-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = start;
        for (int k = 0; k < S; k++) begin
            int cand;
            cand = int'(start) + k;
            if (cand >= S) cand = cand - S;
            if (!any && req[cand]) begin
                any = 1'b1;
                idx = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/cfgbus_lock_ctl.sv
module cfgbus_lock_ctl
    import cfgbus_pkg::*;
#(
    parameter int S  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [S-1:0]  src_valid,
    input  logic          slot_free,
    output logic [S-1:0]  src_ready,
    output logic          take,
    output logic [IW-1:0] take_idx,
    output logic          take_is_addr
);

    localparam logic [IW-1:0] LAST_IDX = IW'(S - 1);

    phase_e        phase_q;
    logic [IW-1:0] owner_q;
    logic [IW-1:0] ptr_q;

    logic          gnt_any;
    logic [IW-1:0] gnt_idx;

    cfgbus_rr_pick #(.S(S), .IW(IW)) u_pick (
        .req   (src_valid),
        .start (ptr_q),
        .any   (gnt_any),
        .idx   (gnt_idx)
    );

    always_comb begin
        src_ready = '0;
        if (slot_free) begin
            if (phase_q == PH_ADDR) begin
                if (gnt_any) src_ready[gnt_idx] = 1'b1;
            end else begin
                src_ready[owner_q] = 1'b1;
            end
        end
    end

    assign take         = |(src_ready & src_valid);
    assign take_idx     = (phase_q == PH_ADDR) ? gnt_idx : owner_q;
    assign take_is_addr = (phase_q == PH_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ADDR;
            owner_q <= '0;
            ptr_q   <= '0;
        end else if (take) begin
            if (phase_q == PH_ADDR) begin
                phase_q <= PH_VALUE;
                owner_q <= gnt_idx;
                ptr_q   <= (gnt_idx == LAST_IDX) ? '0 : gnt_idx + 1'b1;
            end else begin
                phase_q <= PH_ADDR;
            end
        end
    end

    // R6
    one_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_ready));

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (take && take_is_addr) |=> (phase_q == PH_VALUE) && (owner_q == $past(take_idx)));

    // R4
    rr_start_chk: assert property (@(posedge clk) disable iff (rst)
        (take && take_is_addr && src_valid[ptr_q]) |-> (take_idx == ptr_q));

    // R4
    rr_move_chk: assert property (@(posedge clk) disable iff (rst)
        (take && take_is_addr) |=> (ptr_q != $past(take_idx)));

endmodule

// File: rtl/cfgbus_out_stage.sv
module cfgbus_out_stage
    import cfgbus_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  bus_word_t     load_word,
    input  logic [IW-1:0] load_src,
    input  logic          bus_ready,
    output logic          bus_valid,
    output bus_word_t     bus_word,
    output logic [IW-1:0] bus_src,
    output logic          slot_free
);

    assign slot_free = !bus_valid || bus_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_valid <= 1'b0;
            bus_word  <= '0;
            bus_src   <= '0;
        end else if (load) begin
            bus_valid <= 1'b1;
            bus_word  <= load_word;
            bus_src   <= load_src;
        end else if (bus_ready) begin
            bus_valid <= 1'b0;
        end
    end

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> bus_valid && $stable(bus_word) && $stable(bus_src));

    // R6
    load_when_free_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (!bus_valid || bus_ready));

endmodule

// File: rtl/cfgbus_hub.sv
module cfgbus_hub
    import cfgbus_pkg::*;
#(
    parameter int N  = 3,
    parameter int S  = N + 1,
    parameter int IW = idx_width(N + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_valid,
    output logic                ser_ready,
    input  logic [WORD_W-1:0]   ser_data,
    input  logic [N-1:0]        pnl_valid,
    output logic [N-1:0]        pnl_ready,
    input  logic [N*WORD_W-1:0] pnl_data,
    output logic                bus_valid,
    input  logic                bus_ready,
    output logic [WORD_W-1:0]   bus_data,
    output logic                bus_addr_phase,
    output logic [IW-1:0]       bus_src
);

    logic [S-1:0]  src_valid;
    logic [S-1:0]  src_ready;
    word_t         src_word [S];

    logic          take;
    logic [IW-1:0] take_idx;
    logic          take_is_addr;
    logic          slot_free;
    bus_word_t     load_word;
    bus_word_t     out_word;

    // source 0 is the serial link, sources 1..N are the panels
    assign src_valid[0] = ser_valid;
    assign src_word[0]  = ser_data;
    assign ser_ready    = src_ready[0];

    for (genvar g = 0; g < N; g++) begin : g_panel
        assign src_valid[g+1] = pnl_valid[g];
        assign src_word[g+1]  = pnl_data[g*WORD_W +: WORD_W];
        assign pnl_ready[g]   = src_ready[g+1];
    end

    cfgbus_lock_ctl #(.S(S), .IW(IW)) u_lock (
        .clk          (clk),
        .rst          (rst),
        .src_valid    (src_valid),
        .slot_free    (slot_free),
        .src_ready    (src_ready),
        .take         (take),
        .take_idx     (take_idx),
        .take_is_addr (take_is_addr)
    );

    assign load_word.data    = src_word[take_idx];
    assign load_word.is_addr = take_is_addr;

    cfgbus_out_stage #(.IW(IW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (take),
        .load_word (load_word),
        .load_src  (take_idx),
        .bus_ready (bus_ready),
        .bus_valid (bus_valid),
        .bus_word  (out_word),
        .bus_src   (bus_src),
        .slot_free (slot_free)
    );

    assign bus_data       = out_word.data;
    assign bus_addr_phase = out_word.is_addr;

    // pair tracker on the bus side, for the ordering properties
    logic          pair_open_q;
    logic [IW-1:0] pair_src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_open_q <= 1'b0;
            pair_src_q  <= '0;
        end else if (bus_valid && bus_ready) begin
            pair_open_q <= bus_addr_phase;
            pair_src_q  <= bus_src;
        end
    end

    // R2
    pair_order_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready) |-> (bus_addr_phase == !pair_open_q));

    // R3
    pair_src_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready && pair_open_q) |-> (bus_src == pair_src_q));

    // R6
    stall_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |-> (src_ready == '0));

endmodule

// File: tb/cfgbus_hub_tb.sv
module cfgbus_hub_tb;

    localparam int PERIOD = 10;
    localparam int NP     = 3;
    localparam int S      = NP + 1;
    localparam int IW     = 2;
    localparam int NVEC   = 7;

    // {count p3, count p2, count p1, count serial} (2 bits each), bus_ready pattern
    localparam logic [15:0] VEC [NVEC] = '{
        16'h55FF, 16'h12FF, 16'h4CAA, 16'hFFCF, 16'h8071, 16'h0101, 16'h2837
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [S-1:0]        drv_valid = '0;
    logic [15:0]         drv_data [S];
    logic                bus_ready = 1'b0;
    logic                ser_ready;
    logic [NP-1:0]       pnl_ready;
    logic [NP*16-1:0]    pnl_data;
    logic                bus_valid;
    logic [15:0]         bus_data;
    logic                bus_addr_phase;
    logic [IW-1:0]       bus_src;
    logic [S-1:0]        rdy;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    for (genvar g = 0; g < NP; g++) begin : g_drv
        assign pnl_data[g*16 +: 16] = drv_data[g+1];
    end
    assign rdy = {pnl_ready, ser_ready};

    cfgbus_hub #(.N(NP)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .ser_valid      (drv_valid[0]),
        .ser_ready      (ser_ready),
        .ser_data       (drv_data[0]),
        .pnl_valid      (drv_valid[S-1:1]),
        .pnl_ready      (pnl_ready),
        .pnl_data       (pnl_data),
        .bus_valid      (bus_valid),
        .bus_ready      (bus_ready),
        .bus_data       (bus_data),
        .bus_addr_phase (bus_addr_phase),
        .bus_src        (bus_src)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    function automatic logic [15:0] word_of(input int v, input int s, input int k, input int ph);
        if (ph == 0) return {8'(16 * s + k + v), 8'(48 + 4 * s + k)};
        return 16'(40960 + 256 * v + 16 * s + k);
    endfunction

    int m_ptr = 0;

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            drv_valid = '0;
            bus_ready = 1'b1;
        end
    endtask

    task automatic run_vector(input int v);
        int cnt [S];
        int left [S];
        int sent [S];
        int pidx [S];
        int ph [S];
        logic [15:0] e_data [32];
        int e_src [32];
        int e_ph [32];
        int nexp, oi, used, total;
        bit prev_stall, own_valid;
        logic [15:0] prev_data;
        int prev_src, prev_ph, own;
        logic [7:0] pat;
        pat = VEC[v][7:0];
        total = 0;
        for (int s = 0; s < S; s++) begin
            cnt[s] = int'(VEC[v][8 + 2*s +: 2]);
            left[s] = cnt[s];
            sent[s] = 0;
            pidx[s] = 0;
            ph[s] = 0;
            total += cnt[s];
        end
        // expected order from the round-robin rule (R4)
        nexp = 0;
        while (total > 0) begin
            bit found;
            found = 0;
            for (int k = 0; k < S; k++) begin
                int c;
                c = (m_ptr + k) % S;
                if (!found && left[c] > 0) begin
                    found = 1;
                    e_data[nexp] = word_of(v, c, sent[c], 0);
                    e_src[nexp] = c; e_ph[nexp] = 1; nexp++;
                    e_data[nexp] = word_of(v, c, sent[c], 1);
                    e_src[nexp] = c; e_ph[nexp] = 0; nexp++;
                    sent[c]++; left[c]--; total--;
                    m_ptr = (c + 1) % S;
                end
            end
        end
        oi = 0; used = -1;
        prev_stall = 0; own_valid = 0; own = 0;
        prev_data = '0; prev_src = 0; prev_ph = 0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            @(negedge clk);
            for (int s = 0; s < S; s++) begin
                drv_valid[s] = (pidx[s] < cnt[s]);
                drv_data[s] = word_of(v, s, pidx[s], ph[s]);
            end
            bus_ready = pat[cyc % 8];
            #1;
            chk($onehot0(rdy), "R6", "ready one-hot", int'(rdy), 0);
            if (prev_stall) begin
                chk(bus_valid && bus_data == prev_data && int'(bus_src) == prev_src
                    && int'(bus_addr_phase) == prev_ph, "R5", "held word",
                    int'(bus_data), int'(prev_data));
            end
            if (bus_valid && !bus_ready)
                chk(rdy == '0, "R6", "ready during stall", int'(rdy), 0);
            if (own_valid)
                chk((rdy & ~(S'(1) << own)) == '0, "R3", "foreign ready while locked",
                    int'(rdy), 0);
            if (bus_valid && bus_ready) begin
                if (oi < nexp) begin
                    chk(bus_data == e_data[oi], "R2", "bus word", int'(bus_data), int'(e_data[oi]));
                    chk(int'(bus_src) == e_src[oi], "R4", "bus source", int'(bus_src), e_src[oi]);
                    chk(int'(bus_addr_phase) == e_ph[oi], "R2", "phase flag",
                        int'(bus_addr_phase), e_ph[oi]);
                end else begin
                    chk(0, "R2", "extra bus word", int'(bus_data), 0);
                end
                oi++;
            end
            prev_stall = bus_valid && !bus_ready;
            prev_data = bus_data; prev_src = int'(bus_src); prev_ph = int'(bus_addr_phase);
            for (int s = 0; s < S; s++) begin
                if (drv_valid[s] && rdy[s]) begin
                    if (ph[s] == 0) begin
                        ph[s] = 1; own_valid = 1; own = s;
                    end else begin
                        ph[s] = 0; pidx[s]++; own_valid = 0;
                    end
                end
            end
            if (oi >= nexp) begin
                used = cyc;
                break;
            end
        end
        chk(oi == nexp, "R2", "words delivered", oi, nexp);
        // R7: full-rate vectors finish in one cycle per word after the first take
        if (pat == 8'hFF)
            chk(used == nexp, "R7", "cycles for batch", used, nexp);
        idle(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        for (int s = 0; s < S; s++) drv_data[s] = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(!bus_valid, "R1", "bus_valid after reset", int'(bus_valid), 0);
        chk(rdy == '0, "R1", "readies after reset", int'(rdy), 0);
        m_ptr = 0;

        for (int v = 0; v < NVEC; v++) run_vector(v);

        // R1: reset in the middle of a pair
        @(negedge clk);
        bus_ready = 1'b0;
        drv_valid = '0; drv_valid[2] = 1'b1; drv_data[2] = 16'h0203;
        #1;
        chk(rdy[2] == 1'b1, "R9", "panel channel 1 ready", int'(rdy), 4);
        @(negedge clk);
        drv_valid = '0;
        rst = 1'b1;
        #1;
        chk(bus_valid && bus_src == 2'd2, "R9", "panel channel 1 source index",
            int'(bus_src), 2);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!bus_valid, "R1", "bus empty after mid-pair reset", int'(bus_valid), 0);
        // R4: search restarts at the serial source
        drv_valid[0] = 1'b1; drv_data[0] = 16'hFE01;
        drv_valid[3] = 1'b1; drv_data[3] = 16'h0101;
        bus_ready = 1'b1;
        #1;
        chk(rdy == 4'b0001, "R4", "serial wins after reset", int'(rdy), 1);
        @(negedge clk);
        drv_valid[0] = 1'b0;
        #1;
        chk(bus_valid && bus_addr_phase && bus_src == 2'd0, "R1", "new pair starts with address",
            int'(bus_addr_phase), 1);
        chk(bus_data[15:8] == 8'hFE && bus_data[7:0] == 8'h01, "R8", "panel and device bytes",
            int'(bus_data), 16'hFE01);
        // R3: owner idle, panel 3 valid, must wait
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk(rdy[3] == 1'b0, "R3", "waiting panel locked out", int'(rdy), 1);
        end
        @(negedge clk);
        drv_valid[0] = 1'b1; drv_data[0] = 16'h00AA;
        #1;
        chk(rdy == 4'b0001, "R3", "owner takes value", int'(rdy), 1);
        @(negedge clk);
        drv_valid[0] = 1'b0;
        #1;
        chk(bus_valid && !bus_addr_phase && bus_data == 16'h00AA && bus_src == 2'd0,
            "R2", "value follows its address", int'(bus_data), 16'h00AA);
        chk(rdy == 4'b1000, "R4", "panel 3 granted next", int'(rdy), 8);
        idle(2);
        summary();
    end

endmodule